// File: doc/BRIEF.md
# BCD Double, Quadruple and Quintuple Generator

This block takes a multiplicand of `N_DIGITS` packed BCD digits and drives three multiples of it at once: twice, four times and five times the operand, each one digit wider than the input. It contains no registers and no adder chain. A decimal multiplier's iteration stage can use the three multiples directly from the held operand, with no clock cycles spent building them and no storage for them.

Each output digit is formed from two neighbouring input digits only. When a BCD digit is doubled, the low bit of the result is zero. Any carry lands in that empty bit and stops there. When a digit is multiplied by five, it first becomes 5 if it is odd and 0 if it is even. The incoming carry from the digit below is at most 4, so the sum never passes 9. Because of this, no carry crosses more than one digit boundary. The four-times result reuses the doubling stage on the doubled word.

Operands containing a digit code from 1010 to 1111 are outside the contract. For such operands the outputs are not defined.

Top module: `bcd_multiple_gen`

## Requirements
- R1: `dbl_o` holds the value 2×A as `N_DIGITS+1` packed BCD digits, with digit i in bits [4i+3:4i].
- R2: `quad_o` holds the value 4×A as `N_DIGITS+1` packed BCD digits.
- R3: `quint_o` holds the value 5×A as `N_DIGITS+1` packed BCD digits.
- R4: The top digit of `dbl_o` is 1 when the top input digit is 5 or more, and 0 otherwise.
- R5: The top digit of `quad_o` is never above 3. The top digit of `quint_o` equals the top input digit divided by two, rounded down, so it is never above 4.
- R6: Digit 0 of `dbl_o` equals (2×a0) mod 10. Digit 0 of `quint_o` is 5 when a0 is odd and 0 when a0 is even.
- R7: Changing input digit k alone can change only digits k and k+1 of `dbl_o` and `quint_o`, and only digits k to k+2 of `quad_o`.
- R8: The outputs are a function of `a_i` alone. They follow a new operand within the same clock period, with no clock and no held state.
- R9: Every output digit is a valid BCD code (0 to 9) whenever every input digit is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4*N_DIGITS | Multiplicand, packed BCD, digit 0 least significant |
| dbl_o | output | 4*(N_DIGITS+1) | Two times the multiplicand, packed BCD |
| quad_o | output | 4*(N_DIGITS+1) | Four times the multiplicand, packed BCD |
| quint_o | output | 4*(N_DIGITS+1) | Five times the multiplicand, packed BCD |

## Verification
The hardest case to reach is a locality fault, where a digit cell reads from the wrong neighbour or takes in a carry from two places below. Ordinary operands often hide this, because the affected digits happen to match. The stimulus therefore takes fixed operands, changes a single digit in every position, and confirms that no output digit outside the allowed window moves. A second two-digit instance is swept through all 100 valid operands so that every pair of neighbouring digit values occurs. Random valid operands on the wide instance then exercise the carries at the top digit.

// File: rtl/bcd_mult_pkg.sv
`timescale 1ns/1ps
package bcd_mult_pkg;

  typedef logic [3:0] bcd_digit_t;

  // Carry from doubling: set when the digit is 5..9.
  function automatic logic dbl_carry(input bcd_digit_t d);
    return d[3] | (d[2] & (d[1] | d[0]));
  endfunction

  // Upper three bits of (2*d mod 10); the low bit is always zero.
  function automatic logic [2:0] dbl_upper(input bcd_digit_t d);
    logic [2:0] r;
    if (dbl_carry(d)) r = 3'(d - 4'd5);
    else              r = d[2:0];
    return r;
  endfunction

endpackage

// File: rtl/bcd_dbl_cell.sv
`timescale 1ns/1ps
module bcd_dbl_cell
  import bcd_mult_pkg::*;
(
  input  bcd_digit_t cur_i,
  input  logic       carry_in_i,
  output bcd_digit_t out_o
);
  assign out_o = {dbl_upper(cur_i), carry_in_i};
endmodule

// File: rtl/bcd_quint_cell.sv
`timescale 1ns/1ps
module bcd_quint_cell
  import bcd_mult_pkg::*;
(
  input  logic       cur_odd_i,
  input  logic [2:0] prev_half_i,
  output bcd_digit_t out_o
);
  // prev_half_i is at most 4, so 5 + prev_half_i never exceeds 9.
  assign out_o = (cur_odd_i ? 4'd5 : 4'd0) + {1'b0, prev_half_i};
endmodule

// File: rtl/bcd_dbl_word.sv
`timescale 1ns/1ps
module bcd_dbl_word
  import bcd_mult_pkg::*;
#(
  parameter int ND_IN  = 8,
  parameter int ND_OUT = ND_IN + 1
) (
  input  logic [4*ND_IN-1:0]  in_i,
  output logic [4*ND_OUT-1:0] out_o
);
  localparam int ND_CELLS = (ND_OUT < ND_IN) ? ND_OUT : ND_IN;

  logic [ND_IN:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < ND_IN; i++) begin : g_carry
    assign carry[i+1] = dbl_carry(in_i[4*i +: 4]);
  end

  for (genvar i = 0; i < ND_CELLS; i++) begin : g_cell
    bcd_dbl_cell u_cell (
      .cur_i      (in_i[4*i +: 4]),
      .carry_in_i (carry[i]),
      .out_o      (out_o[4*i +: 4])
    );
  end

  if (ND_OUT > ND_IN) begin : g_top
    assign out_o[4*ND_IN +: 4] = {3'b000, carry[ND_IN]};
    if (ND_OUT > ND_IN + 1) begin : g_pad
      assign out_o[4*ND_OUT-1 : 4*(ND_IN+1)] = '0;
    end
  end
endmodule

// File: rtl/bcd_quint_word.sv
`timescale 1ns/1ps
module bcd_quint_word
  import bcd_mult_pkg::*;
#(
  parameter int ND_IN = 8
) (
  input  logic [4*ND_IN-1:0]     in_i,
  output logic [4*(ND_IN+1)-1:0] out_o
);
  for (genvar i = 0; i <= ND_IN; i++) begin : g_cell
    logic       odd_bit;
    logic [2:0] half_prev;
    if (i == 0) begin : g_low
      assign half_prev = 3'd0;
    end else begin : g_mid
      assign half_prev = in_i[4*(i-1)+1 +: 3];
    end
    if (i == ND_IN) begin : g_top
      assign odd_bit = 1'b0;
    end else begin : g_body
      assign odd_bit = in_i[4*i];
    end
    bcd_quint_cell u_cell (
      .cur_odd_i   (odd_bit),
      .prev_half_i (half_prev),
      .out_o       (out_o[4*i +: 4])
    );
  end
endmodule

// File: rtl/bcd_multiple_gen.sv
`timescale 1ns/1ps
module bcd_multiple_gen #(
  parameter int N_DIGITS = 8
) (
  input  logic [4*N_DIGITS-1:0]     a_i,
  output logic [4*(N_DIGITS+1)-1:0] dbl_o,
  output logic [4*(N_DIGITS+1)-1:0] quad_o,
  output logic [4*(N_DIGITS+1)-1:0] quint_o
);
  localparam int NW = N_DIGITS + 1;

  logic [4*NW-1:0] dbl_w;

  bcd_dbl_word #(.ND_IN(N_DIGITS), .ND_OUT(NW)) u_dbl (
    .in_i  (a_i),
    .out_o (dbl_w)
  );

  // The top digit of 2A is at most 1, so doubling again needs no extra digit.
  bcd_dbl_word #(.ND_IN(NW), .ND_OUT(NW)) u_quad (
    .in_i  (dbl_w),
    .out_o (quad_o)
  );

  bcd_quint_word #(.ND_IN(N_DIGITS)) u_quint (
    .in_i  (a_i),
    .out_o (quint_o)
  );

  assign dbl_o = dbl_w;
endmodule

// File: rtl/bcd_multiple_gen_chk.sv
`timescale 1ns/1ps
module bcd_multiple_gen_chk #(
  parameter int N_DIGITS = 8
) (
  input logic [4*N_DIGITS-1:0]     a_i,
  input logic [4*(N_DIGITS+1)-1:0] dbl_o,
  input logic [4*(N_DIGITS+1)-1:0] quad_o,
  input logic [4*(N_DIGITS+1)-1:0] quint_o
);
  localparam int NW = N_DIGITS + 1;

  logic in_ok, dbl_ok, quad_ok, quint_ok;

  always_comb begin
    in_ok = 1'b1;
    for (int i = 0; i < N_DIGITS; i++) if (a_i[4*i +: 4] > 4'd9) in_ok = 1'b0;
    dbl_ok = 1'b1; quad_ok = 1'b1; quint_ok = 1'b1;
    for (int i = 0; i < NW; i++) begin
      if (dbl_o[4*i +: 4]   > 4'd9) dbl_ok   = 1'b0;
      if (quad_o[4*i +: 4]  > 4'd9) quad_ok  = 1'b0;
      if (quint_o[4*i +: 4] > 4'd9) quint_ok = 1'b0;
    end
  end

  always_comb begin
    if (in_ok) begin
      p_dbl_top_r4: assert (dbl_o[4*N_DIGITS +: 4] <= 4'd1)
        else $error("dbl top digit above 1");
      p_quad_top_r5: assert (quad_o[4*N_DIGITS +: 4] <= 4'd3)
        else $error("quad top digit above 3");
      p_quint_top_r5: assert (quint_o[4*N_DIGITS +: 4] <= 4'd4)
        else $error("quint top digit above 4");
      p_quint_low_r6: assert (quint_o[3:0] == 4'd0 || quint_o[3:0] == 4'd5)
        else $error("quint low digit not 0 or 5");
      p_dbl_even_r6: assert (dbl_o[0] == 1'b0)
        else $error("dbl low digit odd");
      p_digits_valid_r9: assert (dbl_ok && quad_ok && quint_ok)
        else $error("output digit above 9");
    end
  end
endmodule

bind bcd_multiple_gen bcd_multiple_gen_chk #(.N_DIGITS(N_DIGITS)) u_chk (
  .a_i     (a_i),
  .dbl_o   (dbl_o),
  .quad_o  (quad_o),
  .quint_o (quint_o)
);

// File: tb/bcd_multiple_gen_bench.sv
`timescale 1ns/1ps
module bcd_multiple_gen_bench;
  localparam int ND  = 4;
  localparam int NDS = 2;
  localparam int NV  = 11;

  localparam logic [15:0] VA [NV] = '{16'h0000, 16'h0001, 16'h0005, 16'h0009,
    16'h9999, 16'h1234, 16'h5555, 16'h8642, 16'h1357, 16'h5000, 16'h4999};
  localparam logic [19:0] V2 [NV] = '{20'h00000, 20'h00002, 20'h00010, 20'h00018,
    20'h19998, 20'h02468, 20'h11110, 20'h17284, 20'h02714, 20'h10000, 20'h09998};
  localparam logic [19:0] V4 [NV] = '{20'h00000, 20'h00004, 20'h00020, 20'h00036,
    20'h39996, 20'h04936, 20'h22220, 20'h34568, 20'h05428, 20'h20000, 20'h19996};
  localparam logic [19:0] V5 [NV] = '{20'h00000, 20'h00005, 20'h00025, 20'h00045,
    20'h49995, 20'h06170, 20'h27775, 20'h43210, 20'h06785, 20'h25000, 20'h24995};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [4*ND-1:0]      a;
  logic [4*(ND+1)-1:0]  d2, d4, d5;
  logic [4*NDS-1:0]     as;
  logic [4*(NDS+1)-1:0] s2, s4, s5;

  bcd_multiple_gen #(.N_DIGITS(ND)) u_bcd_multiple_gen (
    .a_i(a), .dbl_o(d2), .quad_o(d4), .quint_o(d5));
  bcd_multiple_gen #(.N_DIGITS(NDS)) u_bcd_multiple_gen_n2 (
    .a_i(as), .dbl_o(s2), .quad_o(s4), .quint_o(s5));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint bcd2int(input logic [31:0] v, input int nd);
    longint r = 0;
    for (int i = nd - 1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [31:0] int2bcd(input longint x, input int nd);
    logic [31:0] r = '0;
    longint t = x;
    for (int i = 0; i < nd; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic full_check(input logic [15:0] av);
    longint v = bcd2int({16'h0, av}, ND);
    a = av;
    #2;
    check("R1", {12'h0, d2}, int2bcd(2 * v, ND + 1));
    check("R2", {12'h0, d4}, int2bcd(4 * v, ND + 1));
    check("R3", {12'h0, d5}, int2bcd(5 * v, ND + 1));
  endtask

  // R7: change digit k alone and confirm only the allowed window moves
  task automatic locality(input logic [15:0] base, input int k, input logic [3:0] nd);
    logic [19:0] b2, b4, b5;
    logic [15:0] m;
    int bad;
    a = base; #2;
    b2 = d2; b4 = d4; b5 = d5;
    m = base; m[4*k +: 4] = nd;
    a = m; #2;
    bad = 0;
    for (int j = 0; j <= ND; j++) begin
      if (j != k && j != k + 1) begin
        if (d2[4*j +: 4] !== b2[4*j +: 4]) bad++;
        if (d5[4*j +: 4] !== b5[4*j +: 4]) bad++;
      end
      if (j < k || j > k + 2)
        if (d4[4*j +: 4] !== b4[4*j +: 4]) bad++;
    end
    check("R7", bad, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    a = '0; as = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // zero operand gives all-zero outputs
    check("R1", {12'h0, d2}, 32'h0);
    check("R3", {12'h0, d5}, 32'h0);

    // vector table, R1 R2 R3
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      a = VA[i]; #2;
      check("R1", {12'h0, d2}, {12'h0, V2[i]});
      check("R2", {12'h0, d4}, {12'h0, V4[i]});
      check("R3", {12'h0, d5}, {12'h0, V5[i]});
    end

    // R4 top digit of 2A
    a = 16'h4999; #2; check("R4", {28'h0, d2[19:16]}, 32'd0);
    a = 16'h5000; #2; check("R4", {28'h0, d2[19:16]}, 32'd1);
    // R5 top digits
    a = 16'h9999; #2;
    check("R5", {28'h0, d4[19:16]}, 32'd3);
    check("R5", {28'h0, d5[19:16]}, 32'd4);
    a = 16'h7000; #2; check("R5", {28'h0, d5[19:16]}, 32'd3);
    // R6 low digits
    a = 16'h9997; #2;
    check("R6", {28'h0, d2[3:0]}, 32'd4);
    check("R6", {28'h0, d5[3:0]}, 32'd5);
    a = 16'h9998; #2; check("R6", {28'h0, d5[3:0]}, 32'd0);

    // R8: operand changes mid-period, outputs follow with no clock edge
    @(posedge clk); #1;
    a = 16'h0007; #1;
    check("R8", {12'h0, d2}, 32'h14);
    a = 16'h0003; #1;
    check("R8", {12'h0, d5}, 32'h15);

    // R7 locality in every position
    for (int k = 0; k < ND; k++) begin
      locality(16'h1234, k, 4'd9);
      locality(16'h9876, k, 4'd0);
      locality(16'h5555, k, 4'd4);
    end

    // exhaustive sweep of the two-digit instance, R1 R2 R3 R9
    for (int v = 0; v < 100; v++) begin
      as = int2bcd(longint'(v), NDS)[7:0];
      #2;
      check("R1", {20'h0, s2}, int2bcd(2 * v, NDS + 1));
      check("R2", {20'h0, s4}, int2bcd(4 * v, NDS + 1));
      check("R3", {20'h0, s5}, int2bcd(5 * v, NDS + 1));
    end

    // random valid operands on the wide instance
    for (int r = 0; r < 300; r++) begin
      logic [15:0] av;
      for (int j = 0; j < ND; j++) av[4*j +: 4] = 4'($urandom % 10);
      full_check(av);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule